// File: doc/BRIEF.md
# Bit-Serial Compute-in-Memory MAC Slice

This block computes one partial dot product between an activation vector and a set of locally held 4-bit weights. Each of the 256 lanes owns a weight nibble kept in writable flop storage, loaded one lane per cycle through a simple address/data write port. The activation vector is not presented as whole words. It arrives one bit plane per clock cycle, least significant plane first, on a 256-bit bus. In each cycle the slice forms the one-bit products of the plane and every weight bit. Each product is a NOR of the inverted operands. A separate population-count tree for each weight bit sums the products of that bit across the lanes.

The four tree sums are merged into a single nibble-weighted value. The top weight bit can count as −8 when the weights are declared signed. A shift accumulator then adds the merged value at the bit position of the current plane. When the activations are declared two's complement, the most significant plane is subtracted instead of added. A start pulse opens a run and a one-cycle done flag closes it. The result is held until the next accepted start. Wider weights are formed outside the slice by combining several slice results with shifts and adds.

Top module: `cim_slice`

## Requirements
- R1: After reset, result_o is 0, done_o is 0 and busy_o is 0.
- R2: A write with wr_en_i high, busy_o low and start_i low stores wr_data_i as the weight of lane wr_addr_i. Bit b of wr_data_i is weight bit b. The write is used by every later run.
- R3: With both signed modes low, result_o equals the sum over lanes of act[i]·w[i], both read as unsigned. This holds without overflow up to all activations 255 and all weights 15 (979200).
- R4: With act_signed_i high at start, each activation is read as an 8-bit two's complement value, because the last plane (bit 7) is subtracted.
- R5: With wt_signed_i high at start, each weight is read as 4-bit two's complement: bit 3 carries −8 and bits 0..2 carry 1, 2 and 4.
- R6: A start accepted with plane 0 on act_plane_i in cycle t takes planes 1..D−1 in cycles t+1..t+D−1. done_o is high for exactly the one cycle after the last plane is taken. busy_o is low in that cycle, and result_o is final in it.
- R7: Once done_o has pulsed, result_o keeps its value until the next accepted start.
- R8: A weight write is rejected when busy_o is high or when start_i is high in the same cycle. Weights never change during a run.
- R9: start_i while busy_o is high is ignored. The run in progress keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Weight write request |
| wr_addr_i | input | 8 | Lane written |
| wr_data_i | input | 4 | Weight nibble |
| start_i | input | 1 | Start of a run; plane 0 is valid in this cycle |
| act_signed_i | input | 1 | Activations are two's complement (sampled at start) |
| wt_signed_i | input | 1 | Weights are two's complement (sampled at start) |
| act_plane_i | input | 256 | Current activation bit plane, one bit per lane |
| result_o | output | 22 | Signed partial dot product |
| done_o | output | 1 | One-cycle pulse when the result is final |
| busy_o | output | 1 | Run in progress |

## Verification
Two pairs of events can meet in one cycle: a weight write with a start, and a weight write or a fresh start with a run in progress. The bench provokes both. It issues a write in the start cycle, then a write and a second start partway through a run. The write targets a lane whose activation has high bits set, so a write that slipped through would change the later planes' sums. The bench judges the outcome by comparing the final result with the value computed from the unchanged weights and by checking that done arrives on the original cycle. A clean follow-up run then confirms that the stored weights were never altered.

// File: rtl/cim_pkg.sv
package cim_pkg;
  typedef struct packed {
    logic act_signed;
    logic wt_signed;
  } cim_mode_t;
endpackage

// File: rtl/cim_weight_store.sv
module cim_weight_store #(
  parameter int N_IN   = 256,
  parameter int W_BITS = 4,
  parameter int AW     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [AW-1:0]                waddr_i,
  input  logic [W_BITS-1:0]            wdata_i,
  output logic [W_BITS-1:0][N_IN-1:0]  col_o
);
  logic [W_BITS-1:0][N_IN-1:0] bits_q;

  // stored by bit column so each tree sees one contiguous vector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
    end else if (we_i) begin
      for (int b = 0; b < W_BITS; b++) bits_q[b][waddr_i] <= wdata_i[b];
    end
  end

  assign col_o = bits_q;
endmodule

// File: rtl/cim_bit_tree.sv
module cim_bit_tree #(
  parameter int N_IN   = 256,
  parameter int TREE_W = $clog2(N_IN + 1)
) (
  input  logic [N_IN-1:0]   act_n_i,
  input  logic [N_IN-1:0]   wt_n_i,
  output logic [TREE_W-1:0] sum_o
);
  logic [N_IN-1:0] prod;

  // NOR of inverted operands == AND of true values
  assign prod = ~(act_n_i | wt_n_i);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N_IN; i++) sum_o = sum_o + TREE_W'(prod[i]);
  end
endmodule

// File: rtl/cim_nibble_combine.sv
module cim_nibble_combine #(
  parameter int W_BITS = 4,
  parameter int TREE_W = 9,
  parameter int NIB_W  = TREE_W + W_BITS + 1
) (
  input  logic [W_BITS-1:0][TREE_W-1:0] sum_i,
  input  logic                          wt_signed_i,
  output logic signed [NIB_W-1:0]       nib_o
);
  always_comb begin
    nib_o = '0;
    for (int b = 0; b < W_BITS; b++) begin
      if (b == W_BITS - 1 && wt_signed_i)
        nib_o = nib_o - (NIB_W'(sum_i[b]) << b);
      else
        nib_o = nib_o + (NIB_W'(sum_i[b]) << b);
    end
  end
endmodule

// File: rtl/cim_shift_acc.sv
module cim_shift_acc #(
  parameter int D_BITS = 8,
  parameter int NIB_W  = 14,
  parameter int ACC_W  = NIB_W + D_BITS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    act_signed_i,
  input  logic signed [NIB_W-1:0] nib_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int IDX_W = (D_BITS > 1) ? $clog2(D_BITS) : 1;

  logic [IDX_W-1:0]        idx_q, cur_idx;
  logic                    busy_q, done_q, active, last;
  logic signed [ACC_W-1:0] acc_q, ext, shifted, term;

  assign cur_idx = busy_q ? idx_q : '0;
  assign active  = busy_q | start_i;
  assign last    = active && (cur_idx == IDX_W'(D_BITS - 1));
  assign ext     = {{(ACC_W-NIB_W){nib_i[NIB_W-1]}}, nib_i};
  assign shifted = ext <<< cur_idx;
  assign term    = (act_signed_i && cur_idx == IDX_W'(D_BITS - 1)) ? -shifted : shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      done_q <= last;
      if (active) begin
        acc_q  <= (start_i ? '0 : acc_q) + term;
        idx_q  <= cur_idx + IDX_W'(1);
        busy_q <= !last;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/cim_slice.sv
module cim_slice
  import cim_pkg::*;
#(
  parameter int N_IN   = 256,
  parameter int W_BITS = 4,
  parameter int D_BITS = 8,
  parameter int AW     = $clog2(N_IN),
  parameter int TREE_W = $clog2(N_IN + 1),
  parameter int NIB_W  = TREE_W + W_BITS + 1,
  parameter int ACC_W  = NIB_W + D_BITS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [W_BITS-1:0]       wr_data_i,
  input  logic                    start_i,
  input  logic                    act_signed_i,
  input  logic                    wt_signed_i,
  input  logic [N_IN-1:0]         act_plane_i,
  output logic signed [ACC_W-1:0] result_o,
  output logic                    done_o,
  output logic                    busy_o
);
  logic                         busy, start_ok, wr_ok;
  cim_mode_t                    mode_q, mode_cur;
  logic [W_BITS-1:0][N_IN-1:0]  wt_cols;
  logic [W_BITS-1:0][TREE_W-1:0] bit_sum;
  logic signed [NIB_W-1:0]      nib;
  logic [N_IN-1:0]              act_n;

  assign start_ok = start_i & ~busy;
  // writes never land in a run, nor in the cycle a run opens
  assign wr_ok    = wr_en_i & ~busy & ~start_i;
  assign mode_cur = busy ? mode_q : '{act_signed: act_signed_i, wt_signed: wt_signed_i};
  assign act_n    = ~act_plane_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= '0;
    else if (start_ok) mode_q <= mode_cur;
  end

  cim_weight_store #(.N_IN(N_IN), .W_BITS(W_BITS), .AW(AW)) u_store (
    .clk_i, .rst_ni, .we_i(wr_ok), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .col_o(wt_cols)
  );

  for (genvar b = 0; b < W_BITS; b++) begin : g_tree
    cim_bit_tree #(.N_IN(N_IN), .TREE_W(TREE_W)) u_tree (
      .act_n_i(act_n), .wt_n_i(~wt_cols[b]), .sum_o(bit_sum[b])
    );
  end

  cim_nibble_combine #(.W_BITS(W_BITS), .TREE_W(TREE_W), .NIB_W(NIB_W)) u_comb (
    .sum_i(bit_sum), .wt_signed_i(mode_cur.wt_signed), .nib_o(nib)
  );

  cim_shift_acc #(.D_BITS(D_BITS), .NIB_W(NIB_W), .ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .start_i(start_ok), .act_signed_i(mode_cur.act_signed),
    .nib_i(nib), .busy_o(busy), .done_o(done_o), .acc_o(result_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/cim_slice_chk.sv
module cim_slice_chk #(
  parameter int N_IN   = 256,
  parameter int W_BITS = 4,
  parameter int ACC_W  = 22
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        start_i,
  input logic                        busy_o,
  input logic                        done_o,
  input logic [ACC_W-1:0]            result_o,
  input logic [W_BITS-1:0][N_IN-1:0] wt_cols
);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r6_end_flags_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(result_o));

  a_r8_weights_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || start_i) |=> $stable(wt_cols));

  a_r9_run_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind cim_slice cim_slice_chk #(.N_IN(N_IN), .W_BITS(W_BITS), .ACC_W(ACC_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .result_o, .wt_cols
);

// File: tb/cim_slice_test.sv
`timescale 1ns/1ps
module cim_slice_test;
  localparam int N = 256, WB = 4, D = 8, AW = 8, ACC_W = 22;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, as_i = 0, ws_i = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [WB-1:0] wr_data = '0;
  logic [N-1:0] plane = '0;
  logic signed [ACC_W-1:0] result;
  logic done, busy;

  logic [D-1:0]  act_v [N];
  logic [WB-1:0] w_m   [N];
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cim_slice uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .act_signed_i(as_i), .wt_signed_i(ws_i),
    .act_plane_i(plane), .result_o(result), .done_o(done), .busy_o(busy)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(bit as, bit ws);
    int s = 0;
    for (int i = 0; i < N; i++) begin
      int a = as ? int'($signed(act_v[i])) : int'(act_v[i]);
      int w = ws ? int'($signed(w_m[i])) : int'(w_m[i]);
      s += a * w;
    end
    return s;
  endfunction

  task automatic drive_plane(int k);
    for (int i = 0; i < N; i++) plane[i] = act_v[i][k];
  endtask

  task automatic write_w(int addr, int data);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(addr); wr_data = WB'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_weights(int mul, int add);
    for (int i = 0; i < N; i++) begin
      w_m[i] = WB'(i * mul + add);
      write_w(i, int'(w_m[i]));
    end
  endtask

  // inj: write in start cycle, write and restart mid-run (R8, R9)
  task automatic run_mac(bit as, bit ws, string req, bit inj);
    int exp = model(as, ws);
    @(negedge clk);
    start = 1; as_i = as; ws_i = ws; drive_plane(0);
    if (inj) begin wr_en = 1; wr_addr = 0; wr_data = ~w_m[0]; end
    for (int k = 1; k < D; k++) begin
      @(negedge clk);
      start = 0; wr_en = 0; as_i = ~as; ws_i = ~ws;
      drive_plane(k);
      if (inj && k == 3) begin start = 1; wr_en = 1; wr_addr = 0; wr_data = ~w_m[0]; end
      chk({req, " R6 done low mid-run"}, int'(done), 0);
    end
    @(negedge clk);
    start = 0; wr_en = 0;
    chk({req, " R6 done pulse"}, int'(done), 1);
    chk({req, " R6 busy low at done"}, int'(busy), 0);
    chk({req, " result"}, int'(result), exp);
    @(negedge clk);
    chk({req, " R6 done one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    chk({req, " R7 result held"}, int'(result), exp);
  endtask

  task automatic t_reset;
    chk("R1 result", int'(result), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 busy", int'(busy), 0);
  endtask

  task automatic t_unsigned;
    for (int i = 0; i < N; i++) act_v[i] = D'(i * 37 + 11);
    load_weights(7, 3);
    run_mac(0, 0, "R2 R3 unsigned mix", 0);
  endtask

  task automatic t_max;
    for (int i = 0; i < N; i++) act_v[i] = '1;
    load_weights(0, 15);
    run_mac(0, 0, "R3 max no overflow", 0);
    chk("R3 max value", model(0, 0), 979200);
  endtask

  task automatic t_signed;
    for (int i = 0; i < N; i++) act_v[i] = D'(i * 53 + 129);
    load_weights(5, 9);
    run_mac(1, 0, "R4 signed act", 0);
    run_mac(0, 1, "R5 signed wt", 0);
    run_mac(1, 1, "R4 R5 both signed", 0);
    for (int i = 0; i < N; i++) act_v[i] = 8'h80;
    load_weights(0, 8);
    run_mac(1, 1, "R4 R5 extreme", 0);
    chk("R4 R5 extreme value", model(1, 1), 262144);
  endtask

  task automatic t_collide;
    for (int i = 0; i < N; i++) act_v[i] = D'(i * 29 + 200);
    act_v[0] = 8'hF0;
    load_weights(3, 6);
    run_mac(0, 0, "R8 R9 collisions", 1);
    run_mac(0, 0, "R8 weights intact", 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_unsigned();
    t_max();
    t_signed();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule